// File: doc/BRIEF.md
# Way-Locking Replacement Controller

This block picks the victim way for an 8-way set-associative shared cache and keeps the per-set replacement state. A lock mask, written by configuration, splits the ways into two pools. Streaming allocations rotate only inside the locked pool. Normal allocations use only the unlocked pool. Because of this split, a long stream cannot push ordinary data out of the cache. Within a pool, the victim is chosen by a tree pseudo-LRU that is updated on every hit and every fill.

The controller also keeps a valid bit and a dirty bit for each line. It takes four request kinds: a core hit, an allocation, an external read, and a reserved code. An external agent may read a modified line through the external-read request. That request returns the line's dirty status and changes nothing: the line stays resident, stays dirty, and keeps its replacement age. The directory lookup that comes with each request carries a parity-error flag. When that flag is set, the request fails and the stored state is left untouched.

Each request is answered with a registered response one clock later. Requests may be issued on every cycle, including back to back to the same set.

Top module: `waylock_repl`

## Requirements
- R1: After reset, `resp_valid` is low. All replacement state is cleared, so the first allocation to any set with an all-zero mask returns way 0 with `resp_dirty` low.
- R2: A request accepted with `req_valid` high produces exactly one response, with `resp_valid` high, in the next cycle. A cycle without a request produces `resp_valid` low in the next cycle.
- R3: A normal allocation (`req_op` = 1, `req_stream` low) picks its victim only from the ways whose lock-mask bit is 0.
- R4: A streaming allocation (`req_op` = 1, `req_stream` high) with a non-zero mask picks its victim only from the ways whose lock-mask bit is 1.
- R5: With the lock mask all zero, a streaming allocation behaves exactly like a normal allocation over all eight ways.
- R6: With the lock mask all ones, a normal allocation responds with `resp_err` high and changes no state.
- R7: Replacement uses a 7-node binary tree per set. A node bit of 0 steers the victim toward the lower-numbered half. Every hit or fill sets the bits on its path to point away from the touched way. On a fresh set with full permission, successive fills therefore return ways 0, 4, 2, 6, 1, 5, 3, 7, and then 0 again.
- R8: A core hit (`req_op` = 0) on way `req_way` updates that set's tree exactly as a fill of that way would.
- R9: A fill with `req_wr` high leaves the filled line dirty, and a hit with `req_wr` high marks the hit line dirty. An allocation reports `resp_dirty` high when the chosen victim was valid and dirty.
- R10: An external read (`req_op` = 2) returns the dirty bit of line `req_way` on `resp_dirty`. It leaves the line's valid bit, dirty bit and the tree unchanged.
- R11: A request with `req_perr` high, or with the reserved code `req_op` = 3, responds with `resp_err` high and updates no state.
- R12: A mask written with `cfg_we` in one cycle governs every request presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| cfg_we | input | 1 | Write enable for the lock mask |
| cfg_lock_mask | input | WAYS (8) | New lock mask; a 1 bit reserves that way for streaming |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 hit, 1 allocate, 2 external read, 3 reserved |
| req_set | input | SET_W (4) | Set index |
| req_way | input | WAY_W (3) | Way for hit and external read |
| req_stream | input | 1 | Allocation belongs to streaming traffic |
| req_wr | input | 1 | Hit or fill writes the line (marks it dirty) |
| req_perr | input | 1 | Parity error flagged by the directory lookup |
| resp_valid | output | 1 | Response present |
| resp_err | output | 1 | Request failed; no state changed |
| resp_way | output | WAY_W (3) | Victim way for an allocation, echoed way otherwise |
| resp_dirty | output | 1 | Victim needs write-back (allocation) or line is dirty (hit, external read) |

## Verification
Every response is due exactly one clock after its request. The request is captured at a rising edge, and the response register loads at that same edge. The bench therefore drives a request on a falling edge and reads the response on the next falling edge, away from the edge that changes it. State effects (tree age, dirty bits, lock mask) show up only in later requests. Each follow-up allocation or external read is issued after the earlier response has been sampled, and its result is compared with the value the requirement predicts.

// File: rtl/waylock_pkg.sv
package waylock_pkg;

  typedef enum logic [1:0] {
    OP_HIT   = 2'd0,
    OP_ALLOC = 2'd1,
    OP_XREAD = 2'd2,
    OP_RSVD  = 2'd3
  } waylock_op_e;

endpackage

// File: rtl/waylock_rst_sync.sv
module waylock_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  // assert asynchronously, release after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/waylock_victim_pick.sv
module waylock_victim_pick #(
  parameter  int WAYS  = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  plru,
  input  logic [WAYS-1:0]  allow,
  output logic [WAY_W-1:0] victim
);

  // Walk the tree from the root. Follow the stored direction unless
  // that half holds no permitted way, in which case take the other.
  always_comb begin
    int   node;
    int   span;
    int   half;
    int   base;
    logic left_any;
    logic right_any;
    logic go_r;
    node = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      span      = WAYS >> lvl;
      half      = span >> 1;
      base      = (node - (1 << lvl)) * span;
      left_any  = 1'b0;
      right_any = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if (w >= base && w < base + half)
          left_any = left_any | allow[w];
        if (w >= base + half && w < base + span)
          right_any = right_any | allow[w];
      end
      go_r = plru[node-1];
      if (go_r && !right_any)
        go_r = 1'b0;
      else if (!go_r && !left_any)
        go_r = 1'b1;
      node = 2 * node + int'(go_r);
    end
    victim = WAY_W'(node - WAYS);
  end

  always_comb begin
    if (|allow) begin
      AST_VICTIM_PERMITTED: assert (allow[victim]); // R3
    end
  end

endmodule

// File: rtl/waylock_plru_touch.sv
module waylock_plru_touch #(
  parameter  int WAYS  = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  plru_old,
  input  logic [WAY_W-1:0] way,
  output logic [WAYS-2:0]  plru_new
);

  // Each node on the path of the touched way is set to point away from it.
  always_comb begin
    int node;
    plru_new = plru_old;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      node = (1 << lvl) + (int'(way) >> (WAY_W - lvl));
      plru_new[node-1] = ~way[WAY_W-1-lvl];
    end
  end

endmodule

// File: rtl/waylock_state_array.sv
module waylock_state_array #(
  parameter  int WAYS  = 8,
  parameter  int SETS  = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAYS-2:0]  rd_plru,
  output logic [WAYS-1:0]  rd_valid,
  output logic [WAYS-1:0]  rd_dirty,
  input  logic             we,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAYS-2:0]  wr_plru,
  input  logic [WAYS-1:0]  wr_valid,
  input  logic [WAYS-1:0]  wr_dirty
);

  logic [SETS-1:0][WAYS-2:0] plru_all;
  logic [SETS-1:0][WAYS-1:0] valid_all;
  logic [SETS-1:0][WAYS-1:0] dirty_all;

  for (genvar s = 0; s < SETS; s++) begin : g_row
    logic            row_en;
    logic [WAYS-2:0] plru_q;
    logic [WAYS-1:0] valid_q;
    logic [WAYS-1:0] dirty_q;

    assign row_en = we && (wr_set == SET_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        plru_q  <= '0;
        valid_q <= '0;
        dirty_q <= '0;
      end else if (row_en) begin
        plru_q  <= wr_plru;
        valid_q <= wr_valid;
        dirty_q <= wr_dirty;
      end
    end

    assign plru_all[s]  = plru_q;
    assign valid_all[s] = valid_q;
    assign dirty_all[s] = dirty_q;
  end

  assign rd_plru  = plru_all[rd_set];
  assign rd_valid = valid_all[rd_set];
  assign rd_dirty = dirty_all[rd_set];

  AST_ROWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (plru_all == $past(plru_all) && valid_all == $past(valid_all)
             && dirty_all == $past(dirty_all))); // R10

endmodule

// File: rtl/waylock_repl.sv
module waylock_repl
  import waylock_pkg::*;
#(
  parameter  int WAYS  = 8,
  parameter  int SETS  = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [WAYS-1:0]  cfg_lock_mask,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [SET_W-1:0] req_set,
  input  logic [WAY_W-1:0] req_way,
  input  logic             req_stream,
  input  logic             req_wr,
  input  logic             req_perr,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [WAY_W-1:0] resp_way,
  output logic             resp_dirty
);

  logic             rst_n_s;
  logic [WAYS-1:0]  lock_q;

  logic [WAYS-2:0]  rd_plru;
  logic [WAYS-1:0]  rd_valid;
  logic [WAYS-1:0]  rd_dirty;
  logic [WAYS-2:0]  nx_plru;
  logic [WAYS-1:0]  nx_valid;
  logic [WAYS-1:0]  nx_dirty;
  logic             row_we;

  waylock_op_e      op;
  logic             stream_eff;
  logic [WAYS-1:0]  allow;
  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] target;
  logic [WAYS-1:0]  tgt_oh;
  logic [WAYS-1:0]  wr_oh;
  logic             req_err;
  logic             dirty_d;

  waylock_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  waylock_state_array #(.WAYS(WAYS), .SETS(SETS)) u_state (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_set   (req_set),
    .rd_plru  (rd_plru),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .we       (row_we),
    .wr_set   (req_set),
    .wr_plru  (nx_plru),
    .wr_valid (nx_valid),
    .wr_dirty (nx_dirty)
  );

  waylock_victim_pick #(.WAYS(WAYS)) u_pick (
    .plru   (rd_plru),
    .allow  (allow),
    .victim (victim)
  );

  waylock_plru_touch #(.WAYS(WAYS)) u_touch (
    .plru_old (rd_plru),
    .way      (target),
    .plru_new (nx_plru)
  );

  // ---------------- next-state logic ----------------
  always_comb begin
    op         = waylock_op_e'(req_op);
    stream_eff = req_stream && (|lock_q);
    allow      = stream_eff ? lock_q : ~lock_q;
    target     = (op == OP_ALLOC) ? victim : req_way;
    tgt_oh     = WAYS'(1) << target;
    wr_oh      = req_wr ? tgt_oh : '0;
    req_err    = req_perr || (op == OP_RSVD) || ((op == OP_ALLOC) && (allow == '0));
    row_we     = req_valid && !req_err && ((op == OP_HIT) || (op == OP_ALLOC));

    nx_valid = rd_valid;
    nx_dirty = rd_dirty;
    case (op)
      OP_HIT: begin
        nx_dirty = rd_dirty | wr_oh;
      end
      OP_ALLOC: begin
        nx_valid = rd_valid | tgt_oh;
        nx_dirty = (rd_dirty & ~tgt_oh) | wr_oh;
      end
      default: ;
    endcase

    if (op == OP_ALLOC)
      dirty_d = rd_valid[target] && rd_dirty[target];
    else
      dirty_d = rd_dirty[target];
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lock_q <= '0;
    end else if (cfg_we) begin
      lock_q <= cfg_lock_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_way   <= '0;
      resp_dirty <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_err   <= req_err;
        resp_way   <= target;
        resp_dirty <= dirty_d;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> resp_valid); // R2

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> !resp_valid); // R2

  AST_FULL_LOCK_REFUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_op == 2'd1 && !req_stream && (&lock_q)) |=> resp_err); // R6

  AST_PERR_FAILS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_perr) |=> (resp_valid && resp_err)); // R11

  AST_STREAM_IN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_op == 2'd1 && req_stream && (|lock_q) && !req_perr)
      |=> (!resp_err && (|($past(lock_q) & (WAYS'(1) << resp_way))))); // R4

  AST_NORMAL_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_op == 2'd1 && !req_stream && !req_perr && !(&lock_q))
      |=> (!resp_err && !(|($past(lock_q) & (WAYS'(1) << resp_way))))); // R3

endmodule

// File: tb/waylock_repl_tb.sv
`timescale 1ns/1ps
module waylock_repl_tb;

  localparam int WAYS = 8;
  localparam int SETS = 16;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_lock_mask;
  logic       req_valid;
  logic [1:0] req_op;
  logic [3:0] req_set;
  logic [2:0] req_way;
  logic       req_stream;
  logic       req_wr;
  logic       req_perr;
  logic       resp_valid;
  logic       resp_err;
  logic [2:0] resp_way;
  logic       resp_dirty;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // sampled response of the last request
  logic       s_valid;
  logic       s_err;
  logic [2:0] s_way;
  logic       s_dirty;

  waylock_repl #(.WAYS(WAYS), .SETS(SETS)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_lock_mask (cfg_lock_mask),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_set       (req_set),
    .req_way       (req_way),
    .req_stream    (req_stream),
    .req_wr        (req_wr),
    .req_perr      (req_perr),
    .resp_valid    (resp_valid),
    .resp_err      (resp_err),
    .resp_way      (resp_way),
    .resp_dirty    (resp_dirty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, sample the response one clock later
  task automatic issue(input int op, input int set, input int way,
                       input bit stream, input bit wr, input bit perr);
    @(negedge clk);
    req_valid  = 1'b1;
    req_op     = 2'(op);
    req_set    = 4'(set);
    req_way    = 3'(way);
    req_stream = stream;
    req_wr     = wr;
    req_perr   = perr;
    @(negedge clk);
    s_valid = resp_valid;
    s_err   = resp_err;
    s_way   = resp_way;
    s_dirty = resp_dirty;
    req_valid  = 1'b0;
    req_perr   = 1'b0;
    req_wr     = 1'b0;
    req_stream = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    @(negedge clk);
    cfg_we        = 1'b1;
    cfg_lock_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic alloc_expect(input string req, input int set, input bit stream,
                              input bit wr, input int exp_way);
    issue(1, set, 0, stream, wr, 1'b0);
    check(req, "alloc valid", int'(s_valid), 1);
    check(req, "alloc err", int'(s_err), 0);
    check(req, "alloc way", int'(s_way), exp_way);
  endtask

  task automatic t_reset;
    check("R1", "resp_valid after reset", int'(resp_valid), 0);
    alloc_expect("R1", 0, 1'b0, 1'b0, 0);
    check("R1", "first victim dirty", int'(s_dirty), 0);
  endtask

  task automatic t_order;
    int seq[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    for (int i = 0; i < 8; i++) alloc_expect("R7", 1, 1'b0, 1'b0, seq[i]);
    alloc_expect("R7", 1, 1'b0, 1'b0, 0);
  endtask

  task automatic t_idle;
    issue(1, 9, 0, 1'b0, 1'b0, 1'b0);
    check("R2", "resp one cycle after request", int'(s_valid), 1);
    @(negedge clk);
    check("R2", "no resp after idle cycle", int'(resp_valid), 0);
  endtask

  task automatic t_hit;
    issue(0, 2, 0, 1'b0, 1'b0, 1'b0);
    check("R8", "hit err", int'(s_err), 0);
    alloc_expect("R8", 2, 1'b0, 1'b0, 4);
    issue(0, 2, 2, 1'b0, 1'b0, 1'b0);
    alloc_expect("R8", 2, 1'b0, 1'b0, 6);
  endtask

  task automatic t_lock;
    set_mask(8'hC0);
    alloc_expect("R3", 3, 1'b0, 1'b0, 0);
    alloc_expect("R3", 3, 1'b0, 1'b0, 4);
    alloc_expect("R4", 3, 1'b1, 1'b0, 6);
    alloc_expect("R4", 3, 1'b1, 1'b0, 7);
    alloc_expect("R4", 3, 1'b1, 1'b0, 6);
    alloc_expect("R3", 3, 1'b0, 1'b0, 2);
  endtask

  task automatic t_mask_change;
    // R12: new mask applies to the very next request
    set_mask(8'h0F);
    alloc_expect("R12", 10, 1'b0, 1'b0, 4);
    alloc_expect("R12", 10, 1'b1, 1'b0, 0);
  endtask

  task automatic t_zero_mask;
    set_mask(8'h00);
    alloc_expect("R5", 4, 1'b1, 1'b0, 0);
    alloc_expect("R5", 4, 1'b1, 1'b0, 4);
    alloc_expect("R5", 4, 1'b0, 1'b0, 2);
  endtask

  task automatic t_full_mask;
    set_mask(8'hFF);
    issue(1, 5, 0, 1'b0, 1'b0, 1'b0);
    check("R6", "full-mask normal alloc err", int'(s_err), 1);
    alloc_expect("R6", 5, 1'b1, 1'b0, 0);
    issue(1, 5, 0, 1'b0, 1'b0, 1'b0);
    check("R6", "full-mask normal alloc err again", int'(s_err), 1);
    alloc_expect("R6", 5, 1'b1, 1'b0, 4);
    set_mask(8'h00);
  endtask

  task automatic t_dirty;
    int seq[7] = '{4, 2, 6, 1, 5, 3, 7};
    alloc_expect("R9", 6, 1'b0, 1'b1, 0);
    check("R9", "victim of fresh set not dirty", int'(s_dirty), 0);
    for (int i = 0; i < 7; i++) alloc_expect("R9", 6, 1'b0, 1'b0, seq[i]);
    alloc_expect("R9", 6, 1'b0, 1'b0, 0);
    check("R9", "dirty victim reported", int'(s_dirty), 1);
    alloc_expect("R9", 6, 1'b0, 1'b0, 4);
    check("R9", "clean victim not reported", int'(s_dirty), 0);
  endtask

  task automatic t_xread;
    alloc_expect("R10", 7, 1'b0, 1'b1, 0);
    issue(2, 7, 0, 1'b0, 1'b0, 1'b0);
    check("R10", "xread err", int'(s_err), 0);
    check("R10", "xread dirty", int'(s_dirty), 1);
    issue(2, 7, 0, 1'b0, 1'b0, 1'b0);
    check("R10", "xread dirty retained", int'(s_dirty), 1);
    issue(2, 7, 4, 1'b0, 1'b0, 1'b0);
    check("R10", "xread clean line", int'(s_dirty), 0);
    alloc_expect("R10", 7, 1'b0, 1'b0, 4);
    issue(0, 7, 4, 1'b0, 1'b1, 1'b0);
    issue(2, 7, 4, 1'b0, 1'b0, 1'b0);
    check("R9", "write hit marks dirty", int'(s_dirty), 1);
    issue(2, 7, 0, 1'b0, 1'b0, 1'b0);
    check("R10", "line 0 still dirty", int'(s_dirty), 1);
  endtask

  task automatic t_perr;
    issue(1, 8, 0, 1'b0, 1'b1, 1'b1);
    check("R11", "perr alloc err", int'(s_err), 1);
    alloc_expect("R11", 8, 1'b0, 1'b0, 0);
    check("R11", "perr alloc did not fill", int'(s_dirty), 0);
    issue(0, 8, 4, 1'b0, 1'b1, 1'b1);
    check("R11", "perr hit err", int'(s_err), 1);
    issue(2, 8, 4, 1'b0, 1'b0, 1'b0);
    check("R11", "perr hit left line clean", int'(s_dirty), 0);
    issue(3, 8, 4, 1'b0, 1'b1, 1'b0);
    check("R11", "reserved op err", int'(s_err), 1);
    alloc_expect("R11", 8, 1'b0, 1'b0, 4);
  endtask

  initial begin
    rst_n         = 1'b0;
    cfg_we        = 1'b0;
    cfg_lock_mask = '0;
    req_valid     = 1'b0;
    req_op        = '0;
    req_set       = '0;
    req_way       = '0;
    req_stream    = 1'b0;
    req_wr        = 1'b0;
    req_perr      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_order();
    t_idle();
    t_hit();
    t_lock();
    t_mask_change();
    t_zero_mask();
    t_full_mask();
    t_dirty();
    t_xread();
    t_perr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule